// File: doc/BRIEF.md
# Serial Two-Wire Memory Slave with Read Engine

This block is the slave side of a two-wire serial memory holding 2K bytes, split into eight blocks of 256 bytes. It watches the clock and data lines, finds Start, Stop and repeated Start conditions, and checks each control byte for the fixed device tag. Three bits of the control byte choose the block. A write-direction control byte is followed by a word address and, if the master sends any, data bytes. A read-direction control byte makes the slave shift out stored bytes.

One address pointer is shared by every transaction and kept between them. A word address loads it. Each byte written or sent advances it by one. The pointer supports three kinds of read. A current-address read uses the pointer as it stands. A random read first loads the pointer with a write-direction address phase, then issues a repeated Start and a read. A sequential read keeps going while the master acknowledges each byte. A write-direction address phase with no data loads the pointer and writes nothing.

After a Stop that closes a transaction in which data bytes were written, the slave models an internal write cycle as a fixed number of clock cycles. During that time it refuses to acknowledge any control byte, so a master can poll until the slave answers.

The slave never drives the data line high. It only pulls it low through `sda_oe`. Storage is an internal byte array.

Top module: `sermem_slave`

## Requirements
- R1: After reset `sda_oe` is 0. It is 1 only during an acknowledge slot or while a 0 data bit is being sent. At all other times the data line is released.
- R2: The slave acknowledges a control byte only when its upper four bits are 1010 and no write cycle is in progress. After any other control byte it ignores the bus and leaves the line released until the next Start.
- R3: A write-direction control byte (bit 0 = 0) is followed by a word address byte. The pointer becomes {block bits, word address}, where the block bits are the low BLK_W bits of control-byte bits 3..1 and the word address is the low WORD_W bits of the address byte. Each data byte after that is acknowledged and stored at the pointer, and the pointer then advances by one.
- R4: Random read is a write control byte, a word address, a repeated Start, then a read control byte (bit 0 = 1). It returns the byte stored at that address, most significant bit first.
- R5: When the master acknowledges a sent byte, the slave sends the next byte. When the master does not acknowledge, the transfer ends. The pointer advances by one after every sent byte, including the last one.
- R6: A current-address read returns the byte at the pointer, which is the last accessed address plus one. The block bits of a read control byte do not change the pointer.
- R7: The pointer wraps from all ones to zero, both while reading and while writing.
- R8: A write control byte and word address followed directly by Stop load the pointer, write no data, and start no write cycle. The next control byte is acknowledged at once.
- R9: A Stop that closes a transaction in which at least one data byte was written starts a write cycle of BUSY_CYC clock cycles. Control bytes are not acknowledged during that cycle and are acknowledged after it ends.
- R10: A Start or Stop in the middle of a byte abandons that byte. After a Start the slave waits for a fresh control byte, and the pointer keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; oversamples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| scl | input | 1 | Serial clock line level |
| sda | input | 1 | Serial data line level as seen on the bus |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |

## Verification
All bytes of a small array are written in one long transaction with an arithmetic pattern. Each address is then read back by a separate random read, which separates correct pointer loading from pointer advance. Sequential reads that cross the top address, and current-address reads with mismatching block bits, show whether the pointer wraps and persists rather than being reloaded. Several patterns sit next to each other and are told apart by whether the slave acknowledges: polling during and after the write cycle, a bare address phase, a wrong device tag, and Start or Stop cut into the middle of a byte.

// File: rtl/sermem_pkg.sv
package sermem_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_CTRL, ST_CTRL_ACK, ST_ADDR, ST_ADDR_ACK,
    ST_WDATA, ST_WDATA_ACK, ST_TX, ST_RACK
  } sermem_st_e;
  localparam logic [3:0] DEV_TAG = 4'b1010;
endpackage

// File: rtl/sermem_cond.sv
module sermem_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl,
  input  logic sda,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [2:0] scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= 3'b111;
      sda_p <= 3'b111;
    end else begin
      scl_p <= {scl_p[1:0], scl};
      sda_p <= {sda_p[1:0], sda};
    end
  end

  assign sda_s     = sda_p[1];
  assign scl_rise  = scl_p[1] & ~scl_p[2];
  assign scl_fall  = ~scl_p[1] & scl_p[2];
  assign start_det = scl_p[1] & scl_p[2] & sda_p[2] & ~sda_p[1];
  assign stop_det  = scl_p[1] & scl_p[2] & ~sda_p[2] & sda_p[1];
endmodule

// File: rtl/sermem_array.sv
module sermem_array #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/sermem_ctrl.sv
module sermem_ctrl
  import sermem_pkg::*;
#(
  parameter int BLK_W    = 3,
  parameter int WORD_W   = 8,
  parameter int BUSY_CYC = 10000
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    sda_s,
  input  logic                    scl_rise,
  input  logic                    scl_fall,
  input  logic                    start_det,
  input  logic                    stop_det,
  input  logic [7:0]              rdata,
  output logic [BLK_W+WORD_W-1:0] ptr,
  output logic                    mem_we,
  output logic [BLK_W+WORD_W-1:0] mem_waddr,
  output logic [7:0]              mem_wdata,
  output logic                    sda_oe
);
  localparam int AW = BLK_W + WORD_W;
  localparam int BW = $clog2(BUSY_CYC + 1);

  sermem_st_e       st;
  logic [3:0]       cnt;
  logic [7:0]       shreg;
  logic [BLK_W-1:0] blk;
  logic             rd_dir, more, wrote;
  logic [BW-1:0]    busy_cnt;

  always_ff @(posedge clk) begin
    mem_we <= 1'b0;
    if (rst) begin
      st <= ST_IDLE; cnt <= '0; shreg <= '0; blk <= '0; rd_dir <= 1'b0;
      more <= 1'b0; wrote <= 1'b0; busy_cnt <= '0; ptr <= '0;
      sda_oe <= 1'b0; mem_waddr <= '0; mem_wdata <= '0;
    end else begin
      if (busy_cnt != '0) busy_cnt <= busy_cnt - 1'b1;
      if (stop_det) begin
        st <= ST_IDLE;
        sda_oe <= 1'b0;
        if (wrote) begin
          busy_cnt <= BW'(BUSY_CYC);
          wrote <= 1'b0;
        end
      end else if (start_det) begin
        st <= ST_CTRL;
        sda_oe <= 1'b0;
        cnt <= '0;
      end else begin
        case (st)
          ST_CTRL, ST_ADDR, ST_WDATA: begin
            if (scl_rise && cnt != 4'd8) begin
              shreg <= {shreg[6:0], sda_s};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == 4'd8) begin
              cnt <= '0;
              if (st == ST_CTRL) begin
                if (shreg[7:4] == DEV_TAG && busy_cnt == '0) begin
                  sda_oe <= 1'b1;
                  rd_dir <= shreg[0];
                  if (!shreg[0]) blk <= shreg[BLK_W:1];
                  st <= ST_CTRL_ACK;
                end else begin
                  st <= ST_IDLE;
                end
              end else if (st == ST_ADDR) begin
                ptr <= {blk, shreg[WORD_W-1:0]};
                sda_oe <= 1'b1;
                st <= ST_ADDR_ACK;
              end else begin
                mem_we <= 1'b1;
                mem_waddr <= ptr;
                mem_wdata <= shreg;
                ptr <= ptr + 1'b1;
                wrote <= 1'b1;
                sda_oe <= 1'b1;
                st <= ST_WDATA_ACK;
              end
            end
          end
          ST_CTRL_ACK: if (scl_fall) begin
            cnt <= '0;
            if (rd_dir) begin
              shreg <= rdata;
              sda_oe <= ~rdata[7];
              st <= ST_TX;
            end else begin
              sda_oe <= 1'b0;
              st <= ST_ADDR;
            end
          end
          ST_ADDR_ACK, ST_WDATA_ACK: if (scl_fall) begin
            sda_oe <= 1'b0;
            cnt <= '0;
            st <= ST_WDATA;
          end
          ST_TX: if (scl_fall) begin
            if (cnt == 4'd7) begin
              sda_oe <= 1'b0;
              ptr <= ptr + 1'b1;
              st <= ST_RACK;
            end else begin
              shreg <= {shreg[6:0], 1'b0};
              sda_oe <= ~shreg[6];
              cnt <= cnt + 1'b1;
            end
          end
          ST_RACK: begin
            if (scl_rise) more <= ~sda_s;
            else if (scl_fall) begin
              cnt <= '0;
              if (more) begin
                shreg <= rdata;
                sda_oe <= ~rdata[7];
                st <= ST_TX;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: sda_oe <= 1'b0;
        endcase
      end
    end
  end

  // R1
  oe_slot_chk: assert property (@(posedge clk) disable iff (rst)
    sda_oe |-> (st == ST_CTRL_ACK || st == ST_ADDR_ACK || st == ST_WDATA_ACK || st == ST_TX));
  // R9
  busy_nack_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_CTRL && scl_fall && cnt == 4'd8 && busy_cnt != '0 && !start_det && !stop_det)
      |=> (!sda_oe && st == ST_IDLE));
  // R10
  start_abort_chk: assert property (@(posedge clk) disable iff (rst)
    (start_det && !stop_det) |=> (st == ST_CTRL && !sda_oe && cnt == '0 && $stable(ptr)));
  // R5
  ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_TX && scl_fall && cnt == 4'd7 && !start_det && !stop_det)
      |=> (ptr == AW'($past(ptr) + 1'b1)));
  // R8
  no_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (stop_det && !wrote && busy_cnt == '0) |=> (busy_cnt == '0));
endmodule

// File: rtl/sermem_slave.sv
module sermem_slave #(
  parameter int BLK_W    = 3,
  parameter int WORD_W   = 8,
  parameter int BUSY_CYC = 10000
) (
  input  logic clk,
  input  logic rst,
  input  logic scl,
  input  logic sda,
  output logic sda_oe
);
  localparam int AW = BLK_W + WORD_W;

  logic          sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [7:0]    rdata, mem_wdata;
  logic [AW-1:0] ptr, mem_waddr;
  logic          mem_we;

  sermem_cond i_cond (
    .clk(clk), .rst(rst), .scl(scl), .sda(sda), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  sermem_ctrl #(.BLK_W(BLK_W), .WORD_W(WORD_W), .BUSY_CYC(BUSY_CYC)) i_ctrl (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .rdata(rdata), .ptr(ptr),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .sda_oe(sda_oe)
  );

  sermem_array #(.AW(AW), .DW(8)) i_array (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(ptr), .rdata(rdata)
  );
endmodule

// File: tb/test_sermem_slave.sv
module test_sermem_slave;
  localparam int BLK_W = 2;
  localparam int WORD_W = 4;
  localparam int N = 1 << (BLK_W + WORD_W);
  localparam int BUSY = 300;
  localparam int Q = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic m_low = 1'b0;
  logic sda_oe;
  wire  sda_bus = !(m_low | sda_oe);
  int   checks = 0, errors = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  sermem_slave #(.BLK_W(BLK_W), .WORD_W(WORD_W), .BUSY_CYC(BUSY)) i_sermem_slave (
    .clk(clk), .rst(rst), .scl(scl), .sda(sda_bus), .sda_oe(sda_oe)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  function automatic logic [7:0] cb(input int blk, input bit rd);
    return {4'b1010, 1'b0, 2'(blk), rd};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    m_low = 1'b0; wait_clk(Q);
    scl = 1'b1;   wait_clk(Q);
    m_low = 1'b1; wait_clk(Q);
    scl = 1'b0;   wait_clk(Q);
  endtask

  task automatic i2c_stop();
    m_low = 1'b1; wait_clk(Q);
    scl = 1'b1;   wait_clk(Q);
    m_low = 1'b0; wait_clk(2 * Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_low = ~b[i]; wait_clk(Q);
      scl = 1'b1;    wait_clk(2 * Q);
      scl = 1'b0;    wait_clk(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    m_low = 1'b0; wait_clk(Q);
    scl = 1'b1;   wait_clk(Q);
    ack = !sda_bus; wait_clk(Q);
    scl = 1'b0;   wait_clk(Q);
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] d);
    m_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      wait_clk(Q);
      scl = 1'b1; wait_clk(Q);
      d[i] = sda_bus; wait_clk(Q);
      scl = 1'b0; wait_clk(Q);
    end
    m_low = mack; wait_clk(Q);
    scl = 1'b1;   wait_clk(2 * Q);
    scl = 1'b0;   wait_clk(Q);
    m_low = 1'b0;
  endtask

  task automatic set_ptr(input int a, output bit ack);
    bit k1, k2;
    i2c_start();
    send_byte(cb(a >> WORD_W, 1'b0), k1);
    send_byte(8'(a % (1 << WORD_W)), k2);
    ack = k1 & k2;
  endtask

  task automatic cur_read(input int blk, input string req, input int exp);
    bit k; logic [7:0] d;
    i2c_start();
    send_byte(cb(blk, 1'b1), k);
    recv_byte(1'b0, d);
    i2c_stop();
    check(k && d == 8'(exp), req, int'(d), exp);
  endtask

  initial begin
    bit k;
    logic [7:0] d;
    wait_clk(10);
    rst = 1'b0;
    wait_clk(4);
    // R1: released after reset
    check(sda_oe == 1'b0, "R1", int'(sda_oe), 0);

    // R3: fill whole array in one transaction from address 0
    i2c_start();
    send_byte(cb(0, 1'b0), k);
    check(k, "R2", int'(k), 1);
    send_byte(8'h00, k);
    check(k, "R3", int'(k), 1);
    for (int a = 0; a < N; a++) begin
      send_byte(pat(a), k);
      check(k, "R3", int'(k), 1);
    end
    i2c_stop();

    // R9: poll while busy
    i2c_start();
    send_byte(cb(0, 1'b0), k);
    i2c_stop();
    check(!k, "R9", int'(k), 0);
    wait_clk(BUSY + 40);
    i2c_start();
    send_byte(cb(0, 1'b0), k);
    i2c_stop();
    check(k, "R9", int'(k), 1);

    // R4: random read of every address
    for (int a = 0; a < N; a++) begin
      set_ptr(a, k);
      i2c_start();
      send_byte(cb(3, 1'b1), k);
      recv_byte(1'b0, d);
      i2c_stop();
      check(k && d == pat(a), "R4", int'(d), int'(pat(a)));
    end

    // R6 R7: pointer wrapped to 0, read block bits ignored
    cur_read(3, "R6", int'(pat(0)));

    // R5 R7: sequential read across the top
    set_ptr(N - 4, k);
    i2c_start();
    send_byte(cb(1, 1'b1), k);
    for (int i = 0; i < 8; i++) begin
      recv_byte(i != 7, d);
      check(d == pat((N - 4 + i) % N), "R5", int'(d), int'(pat((N - 4 + i) % N)));
    end
    i2c_stop();
    cur_read(0, "R5", int'(pat(4)));

    // R8: bare address phase
    set_ptr(37, k);
    i2c_stop();
    i2c_start();
    send_byte(cb(0, 1'b0), k);
    i2c_stop();
    check(k, "R8", int'(k), 1);
    cur_read(1, "R8", int'(pat(37)));

    // R2: wrong tag ignored, then later byte also ignored
    i2c_start();
    send_byte(8'hB0, k);
    check(!k, "R2", int'(k), 0);
    send_byte(cb(0, 1'b1), k);
    check(!k && sda_oe == 1'b0, "R2", int'(k), 0);
    i2c_stop();
    cur_read(0, "R2", int'(pat(38)));

    // R10: repeated Start mid-byte, Stop mid-byte
    i2c_start();
    send_bits(8'hA1, 4);
    i2c_start();
    send_byte(cb(0, 1'b1), k);
    recv_byte(1'b0, d);
    i2c_stop();
    check(k && d == pat(39), "R10", int'(d), int'(pat(39)));
    i2c_start();
    send_bits(8'hA1, 3);
    i2c_stop();
    cur_read(2, "R10", int'(pat(40)));

    // R3 R7: write wrapping past top, then read back
    set_ptr(N - 1, k);
    send_byte(~pat(N - 1), k);
    send_byte(~pat(0), k);
    send_byte(~pat(1), k);
    i2c_stop();
    wait_clk(BUSY + 40);
    set_ptr(N - 1, k);
    i2c_start();
    send_byte(cb(0, 1'b1), k);
    for (int i = 0; i < 3; i++) begin
      recv_byte(i != 2, d);
      check(d == ~pat((N - 1 + i) % N), "R7", int'(d), int'(~pat((N - 1 + i) % N)));
    end
    i2c_stop();
    cur_read(0, "R7", int'(pat(2)));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule